// File: doc/BRIEF.md
# Selectable Clock Divider with Gated Passthrough

This block takes a single input clock and produces two output banks from it. The passthrough bank is the input clock itself, passed through an AND gate whose enable is a falling-edge flop. The divided bank carries several identical copies of the input clock divided by 2, 4, 8 or 16. A 2-bit select picks the ratio. Every output comes as a true/complement pair, so a differential driver can be placed after it.

One active-low reset/disable input does two jobs. When it goes low, the divider is cleared at once, with no clock edge needed. The passthrough bank is shut off only at the next falling edge of the input, so a high pulse already under way is never cut short. On release, the level passes through a falling-edge synchronizer. A small gate state machine with two states, GATE_OFF and GATE_ON, then opens the passthrough. The transition "open" (GATE_OFF to GATE_ON) is taken at a falling edge that sees the synchronized release high. The transition "close" (GATE_ON to GATE_OFF) is taken at a falling edge that sees it low. Both self-loops hold the state.

The divider counter only advances while the gate is in GATE_ON. Because of this, the first passthrough pulse and the first counter step fall on the same rising edge, and the two banks come out of reset edge-aligned. A select change is taken only when the counter is at zero, where every divided output is low. Before the first such load, the active ratio holds the parameter `SEL_DEFAULT`, which defaults to divide by 16. This is how an open select pin that reads as ones is modelled.

Top module: `clkdiv_fanout`

## Requirements
- R1: The divided outputs have a period of 2^(sel+1) input cycles with a 50% duty cycle. The select encoding is 00 = divide by 2, 01 = divide by 4, 10 = divide by 8 and 11 = divide by 16, with sel[0] the LSB. Number the enabled rising edges from 1 and let k be the active select. After edge j the true output equals bit k of (j mod 16).
- R2: All divided copies toggle identically. Every complement output is the inverse of its true output, on both banks.
- R3: A new select value is adopted only at enabled rising edges where the 4-bit count is zero before the edge. These are edges 1, 17, 33 and so on. Between those edges the ratio does not change.
- R4: While rst_dis_n is low, every divided true output is low and every divided complement is high. This takes effect immediately, without waiting for a clock edge.
- R5: When rst_dis_n falls during a passthrough high phase, that high phase completes. From the next falling edge onward, pass_p is low and pass_n is high for as long as rst_dis_n stays low.
- R6: After rst_dis_n rises, the passthrough stays low through SYNC_STAGES falling edges. It opens at the rising edge that follows falling edge number SYNC_STAGES+1, and that first pulse lasts the full high phase. The divider makes its first step on that same rising edge, so with divide by 2 the divided output rises together with the first pulse.
- R7: While open, pass_p is high during the input's high phase and low during its low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock |
| rst_dis_n | input | 1 | Active-low reset of the divider and disable of the passthrough |
| sel | input | SEL_W (2) | Divide ratio select, 00 = /2, 01 = /4, 10 = /8, 11 = /16 |
| pass_p | output | 1 | Gated undivided clock, true |
| pass_n | output | 1 | Gated undivided clock, complement |
| div_p | output | NUM_COPIES (2) | Divided clock copies, true |
| div_n | output | NUM_COPIES (2) | Divided clock copies, complement |

## Verification
The bench asserts reset in the middle of a high phase. A gate that cleared asynchronously would cut that pulse short, and a divider that waited for a clock edge would leave its outputs high. After release it counts falling edges before the passthrough opens. It then checks that the first pulse is full width and lands on the same edge as the first divider step. A synchronizer of the wrong depth, or a counter released one edge early, would show up as a missing or skewed first edge. Random select changes at arbitrary cycles are compared against a model that adopts the select only at count-zero edges. A divider that switched ratio at once would produce short periods, and the model would flag them.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Passthrough gate state, updated on input falling edges.
    typedef enum logic {
        GATE_OFF = 1'b0,
        GATE_ON  = 1'b1
    } gate_state_t;

endpackage

// File: rtl/clkdiv_relsync.sv
// Falling-edge release synchronizer: clears at once when rst_dis_n falls,
// releases after SYNC_STAGES falling edges of clk_in.
module clkdiv_relsync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_in,
    input  logic rst_dis_n,
    output logic rel_n
);

    logic [SYNC_STAGES-1:0] chain_q;

    always_ff @(negedge clk_in or negedge rst_dis_n) begin
        if (!rst_dis_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= 1'b1;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign rel_n = chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/clkdiv_gate.sv
// Passthrough gate: two-state machine on the falling edge, so the enable
// only changes while the input clock is low and no runt pulse can form.
module clkdiv_gate
    import clkdiv_pkg::*;
(
    input  logic        clk_in,
    input  logic        rel_n,
    output gate_state_t gate_st,
    output logic        pass_p,
    output logic        pass_n
);

    gate_state_t state_q;
    gate_state_t state_d;
    logic        open_w;

    // State register.
    always_ff @(negedge clk_in) begin
        state_q <= state_d;
    end

    // Transitions: "open" and "close".
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OFF: state_d = rel_n ? GATE_ON : GATE_OFF;
            GATE_ON:  state_d = rel_n ? GATE_ON : GATE_OFF;
            default:  state_d = GATE_OFF;
        endcase
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            GATE_ON:  open_w = 1'b1;
            GATE_OFF: open_w = 1'b0;
            default:  open_w = 1'b0;
        endcase
        pass_p = clk_in & open_w;
        pass_n = ~pass_p;
    end

    assign gate_st = state_q;

endmodule

// File: rtl/clkdiv_counter.sv
// Binary divider counter with select held until count zero and one output
// flop per divided copy.
module clkdiv_counter #(
    parameter int             SEL_W       = 2,
    parameter int             NUM_COPIES  = 2,
    parameter logic [SEL_W-1:0] SEL_DEFAULT = '1
) (
    input  logic                     clk_in,
    input  logic                     rst_dis_n,
    input  logic                     run,
    input  logic [SEL_W-1:0]         sel,
    output logic [(2**SEL_W)-1:0]    cnt_q,
    output logic [SEL_W-1:0]         sel_act,
    output logic [NUM_COPIES-1:0]    div_q
);

    localparam int CNT_W = 2**SEL_W;

    logic [CNT_W-1:0] cnt_nxt;
    logic [SEL_W-1:0] sel_nxt;
    logic             bit_nxt;
    logic             at_zero;

    always_comb begin
        at_zero = (cnt_q == '0);
        cnt_nxt = cnt_q + CNT_W'(1);
        sel_nxt = at_zero ? sel : sel_act;
        bit_nxt = cnt_nxt[sel_nxt];
    end

    always_ff @(posedge clk_in or negedge rst_dis_n) begin
        if (!rst_dis_n) begin
            cnt_q   <= '0;
            sel_act <= SEL_DEFAULT;
        end else if (run) begin
            cnt_q   <= cnt_nxt;
            sel_act <= sel_nxt;
        end
    end

    for (genvar g = 0; g < NUM_COPIES; g++) begin : g_copy
        always_ff @(posedge clk_in or negedge rst_dis_n) begin
            if (!rst_dis_n) begin
                div_q[g] <= 1'b0;
            end else if (run) begin
                div_q[g] <= bit_nxt;
            end
        end
    end

endmodule

// File: rtl/clkdiv_fanout.sv
// Selectable clock divider with a gated passthrough bank.
module clkdiv_fanout
    import clkdiv_pkg::*;
#(
    parameter int               SEL_W       = 2,
    parameter int               NUM_COPIES  = 2,
    parameter int               SYNC_STAGES = 2,
    parameter logic [SEL_W-1:0] SEL_DEFAULT = '1
) (
    input  logic                  clk_in,
    input  logic                  rst_dis_n,
    input  logic [SEL_W-1:0]      sel,
    output logic                  pass_p,
    output logic                  pass_n,
    output logic [NUM_COPIES-1:0] div_p,
    output logic [NUM_COPIES-1:0] div_n
);

    localparam int CNT_W = 2**SEL_W;

    logic             rel_n;
    gate_state_t      gate_st;
    logic             run;
    logic [CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0] sel_act;
    logic [NUM_COPIES-1:0] div_q;

    clkdiv_relsync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) relsync_i (
        .clk_in   (clk_in),
        .rst_dis_n(rst_dis_n),
        .rel_n    (rel_n)
    );

    clkdiv_gate gate_i (
        .clk_in (clk_in),
        .rel_n  (rel_n),
        .gate_st(gate_st),
        .pass_p (pass_p),
        .pass_n (pass_n)
    );

    // The counter steps only once the passthrough is open, so both banks
    // start on the same rising edge.
    assign run = (gate_st == GATE_ON);

    clkdiv_counter #(
        .SEL_W      (SEL_W),
        .NUM_COPIES (NUM_COPIES),
        .SEL_DEFAULT(SEL_DEFAULT)
    ) counter_i (
        .clk_in   (clk_in),
        .rst_dis_n(rst_dis_n),
        .run      (run),
        .sel      (sel),
        .cnt_q    (cnt_q),
        .sel_act  (sel_act),
        .div_q    (div_q)
    );

    for (genvar g = 0; g < NUM_COPIES; g++) begin : g_out
        assign div_p[g] = div_q[g];
        assign div_n[g] = ~div_q[g];
    end

endmodule

// File: rtl/clkdiv_fanout_chk.sv
module clkdiv_fanout_chk
    import clkdiv_pkg::*;
#(
    parameter int SEL_W      = 2,
    parameter int NUM_COPIES = 2
) (
    input logic                     clk_in,
    input logic                     rst_dis_n,
    input logic [NUM_COPIES-1:0]    div_p,
    input gate_state_t              gate_st,
    input logic                     rel_n,
    input logic [(2**SEL_W)-1:0]    cnt,
    input logic [SEL_W-1:0]         sel_act
);

    localparam int CNT_W = 2**SEL_W;

    // R2: every divided copy carries the same level
    p_copies_same_r2: assert property (@(posedge clk_in) disable iff (!rst_dis_n)
        div_p == {NUM_COPIES{div_p[0]}});

    // R1: count advances by one on each open edge
    p_count_step_r1: assert property (@(posedge clk_in) disable iff (!rst_dis_n)
        (gate_st == GATE_ON) |=> ((cnt - $past(cnt)) == CNT_W'(1)));

    // R3: active ratio only changes at a count-zero edge
    p_sel_at_wrap_r3: assert property (@(posedge clk_in) disable iff (!rst_dis_n)
        (sel_act != $past(sel_act)) |-> ($past(cnt) == '0));

    // R6: gate opens only after the synchronized release was seen
    p_gate_after_release_r6: assert property (@(negedge clk_in) disable iff (!rst_dis_n)
        (gate_st == GATE_ON) |-> $past(rel_n));

    // R6: divided edges only appear while the passthrough is open
    p_div_rise_gated_r6: assert property (@(posedge clk_in) disable iff (!rst_dis_n)
        $rose(div_p[0]) |-> ($past(gate_st) == GATE_ON));

endmodule

bind clkdiv_fanout clkdiv_fanout_chk #(
    .SEL_W     (SEL_W),
    .NUM_COPIES(NUM_COPIES)
) chk_i (
    .clk_in   (clk_in),
    .rst_dis_n(rst_dis_n),
    .div_p    (div_p),
    .gate_st  (gate_st),
    .rel_n    (rel_n),
    .cnt      (cnt_q),
    .sel_act  (sel_act)
);

// File: tb/clkdiv_fanout_tb.sv
module clkdiv_fanout_tb_top;

    localparam int NC    = 2;
    localparam int NSYNC = 2;

    logic          clk = 1'b0;
    logic          rst_dis_n = 1'b0;
    logic [1:0]    sel = 2'b00;
    logic          pass_p, pass_n;
    logic [NC-1:0] div_p, div_n;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    bit opened = 0;
    int j = 0;
    int active_k = 3;

    clkdiv_fanout #(
        .SEL_W(2), .NUM_COPIES(NC), .SYNC_STAGES(NSYNC), .SEL_DEFAULT(2'b11)
    ) dut_i (
        .clk_in(clk), .rst_dis_n(rst_dis_n), .sel(sel),
        .pass_p(pass_p), .pass_n(pass_n), .div_p(div_p), .div_n(div_n)
    );

    always #5 clk = ~clk;

    function automatic logic exp_div(input int edge_no, input int k);
        return logic'(((edge_no % 16) >> k) & 1);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic do_reset();
        @(posedge clk);
        #2 rst_dis_n = 1'b0;
        #1 check("R4 divided cleared without edge", 8'(div_p), 8'(0));
        #1 check("R5 pulse in progress completes", 8'(pass_p), 8'(opened));
        repeat (3) begin
            @(posedge clk);
            #2;
            check("R5 passthrough held off", 8'({pass_p, pass_n}), 8'(2'b01));
            check("R4 divided held low", 8'({div_p, div_n}), 8'({{NC{1'b0}}, {NC{1'b1}}}));
        end
        opened = 0;
    endtask

    task automatic release_gate();
        @(posedge clk);
        #2 rst_dis_n = 1'b1;
        for (int n = 1; n <= NSYNC; n++) begin
            @(negedge clk);
            @(posedge clk);
            #2 check("R6 passthrough still closed", 8'(pass_p), 8'(0));
        end
        @(negedge clk);
        j = 0;
    endtask

    task automatic run_cycles(input int n, input bit rnd_sel);
        for (int c = 0; c < n; c++) begin
            logic e;
            @(posedge clk);
            j++;
            if (((j - 1) % 16) == 0) active_k = int'(sel);
            e = exp_div(j, active_k);
            #2;
            check("R7 passthrough high phase", 8'({pass_p, pass_n}), 8'(2'b10));
            check("R1/R3 divided value", 8'(div_p), 8'({NC{e}}));
            check("R2 complements", 8'(div_n), 8'({NC{~e}}));
            if (j == 1) begin
                check("R6 first divided step aligned", 8'(div_p[0]), 8'(active_k == 0));
                #2 check("R6 first pulse full width", 8'(pass_p), 8'(1));
            end
            opened = 1;
            @(negedge clk);
            #2 check("R7 passthrough low phase", 8'({pass_p, pass_n}), 8'(2'b01));
            if (rnd_sel && ($urandom_range(0, 7) == 0)) sel = 2'($urandom_range(0, 3));
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_up();
        end
    end

    initial begin
        int seed_v;
        seed_v = int'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #2;
        check("R4 reset state divided", 8'({div_p, div_n}), 8'({{NC{1'b0}}, {NC{1'b1}}}));
        check("R5 reset state passthrough", 8'({pass_p, pass_n}), 8'(2'b01));

        // Directed: each ratio from a clean release.
        for (int k = 0; k < 4; k++) begin
            sel = 2'(k);
            release_gate();
            run_cycles(48, 1'b0);
            do_reset();
        end

        // Change the select between wraps: must wait for count zero.
        sel = 2'b00;
        release_gate();
        run_cycles(5, 1'b0);
        sel = 2'b11;
        run_cycles(30, 1'b0);
        sel = 2'b01;
        run_cycles(20, 1'b0);
        do_reset();

        // Random select changes, with resets dropped mid-run.
        for (int r = 0; r < 4; r++) begin
            sel = 2'($urandom_range(0, 3));
            release_gate();
            run_cycles(200 + int'($urandom_range(0, 37)), 1'b1);
            do_reset();
        end

        done = 1;
        finish_up();
    end

endmodule